// File: doc/BRIEF.md
# Fixed-Point Time-of-Day Counter

This block keeps a 64-bit system time that grows by a programmable fixed-point increment whenever the oscillator tick input is asserted. The increment is scaled so that the nanosecond count sits at a fixed bit position inside the counter. Software therefore recovers nanoseconds with a right shift alone. With a 6.4 ns tick and the wide variant, the reset increment 0x66666666 places that point at bit 28. For ticks 10x and 100x slower, software loads 0x40000000 (shift 24) or 0x50000000 (shift 21).

Two variants are selected by a parameter. The wide variant adds a 31-bit increment on every tick. The narrow variant adds a 24-bit increment, and an 8-bit period field in the upper byte of the same register sets how many ticks pass between additions. For the narrow variant the increment is pre-shifted right by 7 and the nanosecond shift drops by 7, which gives a reset value of 0x01CCCCCC. Software trims the frequency through a delta write that nudges only the increment value.

Access uses a simple write port and a read port, each with a 2-bit address: 0 is the time low word, 1 is the time high word, 2 is the increment register, and 3 is the trim delta (write only). Software reads the time as the low word followed by the high word. Reading the low word captures the high word, so the pair is coherent.

Top module: `tod_counter`

## Requirements
- R1: After reset the time is 0, the captured high word is 0, and the increment register holds 0x66666666 (wide) or 0x01CCCCCC (narrow).
- R2: On a tick that completes a period, the time grows by the increment value field: bits 30:0 in the wide variant (bit 31 is stored but never added), bits 23:0 in the narrow variant.
- R3: In the narrow variant, bits 31:24 of the increment register give the number of ticks per addition; 0 and 1 both mean every tick. The tick count restarts when the increment register is written.
- R4: In a cycle with no tick and no time write, the time holds its value.
- R5: A write to address 0 replaces time bits 31:0, and a write to address 1 replaces bits 63:32. The other half is kept, and a tick in the same cycle adds nothing and does not count toward the period.
- R6: A read strobe at address 0 captures time bits 63:32 as they stand in that cycle. Reading address 1 returns that captured word, not the live high half.
- R7: A write to address 2 loads the increment register without changing the time. A tick in the same cycle still uses the old increment, and the new one applies from the next tick.
- R8: A write to address 3 adds the write data, taken as two's complement, to the increment value field modulo its width. The bits above the field are kept, and the tick count is not restarted.
- R9: The time wraps modulo 2^64.
- R10: The read data is the time low word at address 0, the captured word at 1, the increment register at 2, and zero at 3. The read data is combinational on the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oscillator tick enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 time low, 1 time high, 2 increment, 3 trim delta) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; at address 0 it captures the high word |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data |

## Verification
A wrong increment value or period count shows at the time low word on the first tick that completes a period, one clock after that tick. A mis-placed field shows within a single addition. A wrong captured high word stays hidden until address 1 is read after a low-word read, so the bench reads the word pair across a carry into the high half. A corrupted trim or tick count only shows once more ticks have passed, which is why the bench compares every clock against its model instead of sampling at the end.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int REG_W = 32,
  parameter int CNT_W = 2 * REG_W,
  parameter int NARROW = 0,
  parameter int WIDE_VAL_W = 31,
  parameter int NARROW_VAL_W = 24,
  parameter int PRESHIFT = 7,
  parameter logic [REG_W-1:0] BASE_INC = 32'h6666_6666
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data
);
  localparam int VAL_W = (NARROW != 0) ? NARROW_VAL_W : WIDE_VAL_W;
  localparam int PER_W = REG_W - NARROW_VAL_W;
  localparam logic [REG_W-1:0] RST_INC = (NARROW != 0)
      ? ((REG_W'(1) << NARROW_VAL_W) | (BASE_INC >> PRESHIFT)) : BASE_INC;

  logic [CNT_W-1:0] sys_time;
  logic [REG_W-1:0] inc_q;
  logic [REG_W-1:0] hi_snap;
  logic [VAL_W-1:0] inc_val;
  logic             step;

  wire time_wr = wr_en && !wr_addr[1];
  wire inc_wr  = wr_en && (wr_addr == 2'd2);
  wire trim_wr = wr_en && (wr_addr == 2'd3);

  assign inc_val = inc_q[VAL_W-1:0];

  generate
    if (NARROW != 0) begin : g_period
      logic [PER_W-1:0] ph_q;
      wire  [PER_W-1:0] per = inc_q[REG_W-1 -: PER_W];
      assign step = tick && !time_wr &&
                    ((PER_W+1)'(ph_q) + (PER_W+1)'(1) >= (PER_W+1)'(per));
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                ph_q <= '0;
        else if (inc_wr || step)   ph_q <= '0;
        else if (tick && !time_wr) ph_q <= ph_q + 1'b1;
    end else begin : g_every
      assign step = tick && !time_wr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            sys_time <= '0;
    else if (wr_en && wr_addr == 2'd0)     sys_time[REG_W-1:0] <= wr_data;
    else if (wr_en && wr_addr == 2'd1)     sys_time[CNT_W-1:REG_W] <= wr_data;
    else if (step)                         sys_time <= sys_time + CNT_W'(inc_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       inc_q <= RST_INC;
    else if (inc_wr) inc_q <= wr_data;
    else if (trim_wr) inc_q <= {inc_q[REG_W-1:VAL_W], inc_val + wr_data[VAL_W-1:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          hi_snap <= '0;
    else if (rd_en && rd_addr == 2'd0)   hi_snap <= sys_time[CNT_W-1:REG_W];

  always_comb
    case (rd_addr)
      2'd0:    rd_data = sys_time[REG_W-1:0];
      2'd1:    rd_data = hi_snap;
      2'd2:    rd_data = inc_q;
      default: rd_data = '0;
    endcase
endmodule

module tod_counter_chk #(
  parameter int REG_W = 32,
  parameter int CNT_W = 64,
  parameter int VAL_W = 31,
  parameter int NARROW = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [REG_W-1:0] wr_data,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic [REG_W-1:0] rd_data,
  input logic [CNT_W-1:0] sys_time,
  input logic [REG_W-1:0] inc_q,
  input logic [REG_W-1:0] hi_snap
);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(sys_time));

  a_r2_every_tick_add: assert property (@(posedge clk) disable iff (!rst_n)
    (NARROW == 0 && tick && !(wr_en && !wr_addr[1]))
      |=> sys_time == $past(sys_time) + CNT_W'($past(inc_q[VAL_W-1:0])));

  a_r5_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0)
      |=> (sys_time[REG_W-1:0] == $past(wr_data)) &&
          (sys_time[CNT_W-1:REG_W] == $past(sys_time[CNT_W-1:REG_W])));

  a_r6_capture_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd0) |=> hi_snap == $past(sys_time[CNT_W-1:REG_W]));

  a_r7_inc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> inc_q == $past(wr_data));

  a_r8_trim_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> inc_q[REG_W-1:VAL_W] == $past(inc_q[REG_W-1:VAL_W]));

  a_r10_addr3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> rd_data == '0);
endmodule

bind tod_counter tod_counter_chk #(.REG_W(REG_W), .CNT_W(CNT_W), .VAL_W(VAL_W), .NARROW(NARROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .sys_time(sys_time), .inc_q(inc_q), .hi_snap(hi_snap)
);

// File: tb/test_tod_counter.sv
`timescale 1ns/1ps
module test_tod_counter;
  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0, wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_w, rd_n;

  always #2 clk = ~clk;

  tod_counter #(.NARROW(0)) i_tod_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_w));

  tod_counter #(.NARROW(1)) i_tod_counter_nar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_n));

  logic [63:0] m_time [2];
  logic [31:0] m_inc  [2];
  logic [31:0] m_snap [2];
  int          m_ph   [2];
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_time[k] = '0; m_snap[k] = '0; m_ph[k] = 0;
    end
    m_inc[0] = 32'h6666_6666;
    m_inc[1] = 32'h01CC_CCCC;
  endtask

  task automatic model_step();
    for (int k = 0; k < 2; k++) begin
      int vw;
      logic [31:0] vmask, per;
      vw = (k == 1) ? 24 : 31;
      vmask = 32'((64'h1 << vw) - 1);
      per = (k == 1) ? {24'd0, m_inc[k][31:24]} : 32'd1;
      if (rd_en && rd_addr == 2'd0) m_snap[k] = m_time[k][63:32];
      if (wr_en && wr_addr == 2'd0) m_time[k][31:0] = wr_data;
      else if (wr_en && wr_addr == 2'd1) m_time[k][63:32] = wr_data;
      else if (tick) begin
        if (m_ph[k] + 1 >= int'(per)) begin
          m_time[k] = m_time[k] + {32'd0, m_inc[k] & vmask};
          m_ph[k] = 0;
        end else m_ph[k] = m_ph[k] + 1;
      end
      if (wr_en && wr_addr == 2'd2) begin
        m_inc[k] = wr_data; m_ph[k] = 0;
      end else if (wr_en && wr_addr == 2'd3)
        m_inc[k] = (m_inc[k] & ~vmask) | ((m_inc[k] + wr_data) & vmask);
    end
  endtask

  function automatic logic [31:0] exp_rd(int k);
    case (rd_addr)
      2'd0: return m_time[k][31:0];
      2'd1: return m_snap[k];
      2'd2: return m_inc[k];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%0d: got %h expected %h", cur_req, what, rd_addr, got, exp);
    end
  endtask

  task automatic compare();
    check("wide", rd_w, exp_rd(0));
    check("narrow", rd_n, exp_rd(1));
  endtask

  task automatic cyc(logic t, logic we, logic [1:0] wa, logic [31:0] wd, logic re, logic [1:0] ra);
    tick = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    cyc(0, 0, 0, 0, 0, 2'd2);
    cyc(0, 0, 0, 0, 0, 2'd0);
    cyc(0, 0, 0, 0, 0, 2'd1);
    cur_req = "R2";
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, 0, 2'd0);
    cur_req = "R6";
    cyc(1, 0, 0, 0, 1, 2'd0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 2'd1);
    cur_req = "R9";
    cyc(0, 1, 2'd1, 32'hFFFF_FFFF, 0, 2'd0);
    cyc(0, 1, 2'd0, 32'hF000_0000, 0, 2'd0);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, 0, 0, 1, 2'd0);
      cyc(1, 0, 0, 0, 0, 2'd1);
    end
    cur_req = "R5";
    cyc(1, 1, 2'd0, 32'h1234_5678, 0, 2'd0);
    cyc(1, 1, 2'd1, 32'h0000_00AB, 1, 2'd0);
    cyc(0, 0, 0, 0, 0, 2'd1);
    cyc(1, 0, 0, 0, 0, 2'd0);
    cur_req = "R7";
    cyc(1, 1, 2'd2, 32'h0300_0100, 0, 2'd0);
    cyc(0, 0, 0, 0, 0, 2'd2);
    cur_req = "R3";
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0, 2'd0);
    for (int i = 0; i < 10; i++) cyc(i[0], 0, 0, 0, 0, 2'd0);
    cyc(1, 1, 2'd0, 32'h0000_0000, 0, 2'd0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 2'd0);
    cur_req = "R8";
    cyc(1, 1, 2'd3, 32'hFFFF_FE00, 0, 2'd2);
    cyc(1, 0, 0, 0, 0, 2'd2);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 2'd0);
    cyc(0, 1, 2'd3, 32'h0000_0205, 0, 2'd2);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 2'd0);
    cur_req = "R3";
    cyc(0, 1, 2'd2, 32'h0000_0010, 0, 2'd2);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 2'd0);
    cur_req = "R4";
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 2'd0);
    cur_req = "R10";
    cyc(1, 0, 0, 0, 0, 2'd3);
    cyc(0, 0, 0, 0, 1, 2'd2);
    cyc(0, 0, 0, 0, 0, 2'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule